// File: doc/BRIEF.md
# Page-Burst Parallel Memory Controller

This block sits between a synchronous host and a page-organised, byte-wide parallel memory. The host presents one byte request at a time over a valid/ready handshake: an address, a write flag and write data. The controller turns each request into chip-enable, write-enable, output-enable, address and data-direction pin activity, and returns read bytes with a one-clock valid strobe.

The address is split into a row and a column. The row is bits 16:3 and the column is bits 2:0. Once a row has been opened, requests to the same row are served as page accesses and chip enable stays asserted. A request to a different row first closes the current row with a precharge, where chip enable is high. The row is also closed after a set number of idle clocks.

A parameter selects between two timing profiles. The slow profile uses one precharge clock and no latency clock. The fast profile adds one initial-latency clock after each row opening and uses two precharge clocks.

Top module: `pgmem_ctrl`

## Requirements
- R1: While reset is asserted, mem_ce_n, mem_we_n and mem_oe_n are high, mem_dq_oe is low, req_ready is high and rsp_valid is low.
- R2: During an access clock, mem_addr carries the full request address. The row is bits 16:3 and the column is bits 2:0.
- R3: A request whose bits 16:3 match the open row is accepted while chip enable is low. mem_ce_n stays low into the following clock and through any run of such page accesses.
- R4: A request to a different row makes mem_ce_n go high for exactly PRE clocks before the new row's first access. PRE is 1 in the slow profile and 2 in the fast profile.
- R5: In the slow profile, N back-to-back same-row reads to an open row are accepted in N consecutive clocks.
- R6: In the fast profile, each row opening is followed by exactly one latency clock before the access clock. In that latency clock mem_ce_n is low, mem_oe_n is high and req_ready is low.
- R7: A write produces one access clock in which mem_we_n is low, mem_dq_oe is high and mem_dq_out equals the write data. mem_we_n is high again in the next clock, so every write gives a separate pulse.
- R8: mem_dq_oe is high only while mem_we_n is low and mem_oe_n is high. mem_oe_n is low only in a read access clock.
- R9: rsp_valid is high for one clock, in the clock after a read access clock. rsp_rdata is the value on mem_dq_in during that access clock.
- R10: After IDLE_CLOSE consecutive clocks with the row open and no request, mem_ce_n goes high.
- R11: req_ready is low during precharge clocks, latency clocks and write access clocks. It is high in the idle state, in the open-row state and in read access clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller accepts a request this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (17) | Byte address; row in bits 16:3, column in bits 2:0 |
| req_wdata | input | DATA_W (8) | Write byte |
| rsp_valid | output | 1 | Read byte valid, one clock |
| rsp_rdata | output | DATA_W (8) | Read byte |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | ADDR_W (17) | Memory address pins |
| mem_dq_out | output | DATA_W (8) | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |
| mem_dq_in | input | DATA_W (8) | Data returned by the memory |

## Verification
A vector table mixes writes and reads that stay in one row, hop between rows and return to rows written earlier. Read-back values show whether address and data reached the memory. The number of chip-enable rises and write pulses shows whether the page accesses and row changes were scheduled correctly. A back-to-back burst of eight column reads on one open row tells single-clock page accesses apart from accesses that stall. Separate directed cases cover the idle-close clock count, the one-clock precharge and no-latency path of the slow profile, and the two-clock precharge and latency clock of a fast-profile instance.

// File: rtl/pgmem_pkg.sv
package pgmem_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LAT,
    ST_ACC,
    ST_OPEN,
    ST_PRE
  } pg_state_e;

  // precharge clocks for a profile
  function automatic int pre_clocks(input bit fast);
    return fast ? 2 : 1;
  endfunction

  // initial-latency clocks after a row opening
  function automatic int lat_clocks(input bit fast);
    return fast ? 1 : 0;
  endfunction

endpackage

// File: rtl/pgmem_idle_timer.sv
module pgmem_idle_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);

  localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    expired = run && (cnt_q == CNT_W'(LIMIT - 1));
    if (!run)         cnt_d = '0;
    else if (expired) cnt_d = cnt_q;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R10
  idle_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> !run);

endmodule

// File: rtl/pgmem_seq.sv
module pgmem_seq
  import pgmem_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int COL_W  = 3,
  parameter int DATA_W = 8,
  parameter bit FAST   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              expired,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              req_ready,
  output pg_state_e         state,
  output logic              cur_write,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] cur_wdata,
  output logic              timer_run,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam int LAT_CLKS = lat_clocks(FAST);
  localparam int PRE_CLKS = pre_clocks(FAST);
  localparam pg_state_e FIRST_ST = (LAT_CLKS > 0) ? ST_LAT : ST_ACC;

  pg_state_e         state_q, state_d;
  logic              pend_q, pend_d;
  logic [1:0]        pre_q, pre_d;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              rv_q, rv_d;
  logic [DATA_W-1:0] rd_q;
  logic              accept, same_row, rd_en;

  always_comb begin
    req_ready = (state_q == ST_IDLE) || (state_q == ST_OPEN) ||
                ((state_q == ST_ACC) && !wr_q);
    accept    = req_valid && req_ready;
    same_row  = req_addr[ADDR_W-1:COL_W] == addr_q[ADDR_W-1:COL_W];
    timer_run = (state_q == ST_OPEN) && !req_valid;
    rd_en     = (state_q == ST_ACC) && !wr_q;
    rv_d      = rd_en;
  end

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = FIRST_ST;
      ST_LAT:  state_d = ST_ACC;
      ST_ACC, ST_OPEN: begin
        if (accept) begin
          state_d = same_row ? ST_ACC : ST_PRE;
          pend_d  = !same_row;
        end else if (state_q == ST_ACC) begin
          state_d = ST_OPEN;
        end else if (expired) begin
          state_d = ST_PRE;
          pend_d  = 1'b0;
        end
      end
      ST_PRE:  if (pre_q == 2'd0) state_d = pend_q ? FIRST_ST : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if ((state_d == ST_PRE) && (state_q != ST_PRE)) pre_d = 2'(PRE_CLKS - 1);
    else if ((state_q == ST_PRE) && (pre_q != 2'd0)) pre_d = pre_q - 1'b1;
    else pre_d = pre_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      pre_q   <= 2'd0;
      rv_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      pre_q   <= pre_d;
      rv_q    <= rv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= mem_dq_in;
  end

  assign state     = state_q;
  assign cur_write = wr_q;
  assign cur_addr  = addr_q;
  assign cur_wdata = wdata_q;
  assign rsp_valid = rv_q;
  assign rsp_rdata = rd_q;

  // R6
  lat_then_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LAT) |=> (state_q == ST_ACC));

endmodule

// File: rtl/pgmem_pins.sv
module pgmem_pins
  import pgmem_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  pg_state_e         state,
  input  logic              cur_write,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [DATA_W-1:0] cur_wdata,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);

  logic in_acc;

  always_comb begin
    in_acc     = (state == ST_ACC);
    mem_ce_n   = (state == ST_IDLE) || (state == ST_PRE);
    mem_we_n   = !(in_acc && cur_write);
    mem_oe_n   = !(in_acc && !cur_write);
    mem_dq_oe  = in_acc && cur_write;
    mem_addr   = cur_addr;
    mem_dq_out = cur_wdata;
  end

endmodule

// File: rtl/pgmem_ctrl.sv
module pgmem_ctrl
  import pgmem_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int COL_W      = 3,
  parameter int DATA_W     = 8,
  parameter bit FAST       = 1'b0,
  parameter int IDLE_CLOSE = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  pg_state_e         state;
  logic              cur_write;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;
  logic              timer_run, expired;

  pgmem_seq #(
    .ADDR_W(ADDR_W), .COL_W(COL_W), .DATA_W(DATA_W), .FAST(FAST)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .expired(expired), .mem_dq_in(mem_dq_in),
    .req_ready(req_ready), .state(state),
    .cur_write(cur_write), .cur_addr(cur_addr), .cur_wdata(cur_wdata),
    .timer_run(timer_run),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  pgmem_idle_timer #(.LIMIT(IDLE_CLOSE)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(timer_run), .expired(expired)
  );

  pgmem_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .state(state), .cur_write(cur_write),
    .cur_addr(cur_addr), .cur_wdata(cur_wdata),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
  );

  // R3
  page_keeps_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && req_valid && req_ready &&
     (req_addr[ADDR_W-1:COL_W] == mem_addr[ADDR_W-1:COL_W])) |=> !mem_ce_n);

  // R4
  pre_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> !req_ready);

  // R7
  we_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |=> mem_we_n);

  // R8
  dq_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && mem_oe_n));

  // R9
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |=> rsp_valid);

endmodule

// File: tb/tb_pgmem_ctrl.sv
module tb_mem_model (
  input  logic        clk,
  input  logic        ce_n,
  input  logic        we_n,
  input  logic        oe_n,
  input  logic [16:0] addr,
  input  logic [7:0]  dq_out,
  input  logic        dq_oe,
  output logic [7:0]  dq_in
);
  logic [7:0] store [logic [16:0]];
  logic       tick = 1'b0;

  always @(posedge clk) begin
    if (!ce_n && !we_n && dq_oe) begin
      store[addr] = dq_out;
      tick = !tick;
    end
  end

  always @(ce_n, oe_n, addr, tick) begin
    if (!ce_n && !oe_n)
      dq_in = store.exists(addr) ? store[addr] : (addr[7:0] ^ 8'h5A);
    else
      dq_in = 8'h00;
  end
endmodule

module tb_pgmem_ctrl;
  localparam int IDLE = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  // slow-profile instance
  logic        s_valid = 1'b0, s_write = 1'b0;
  logic [16:0] s_addr = '0;
  logic [7:0]  s_wdata = '0;
  logic        s_ready, s_rsp, s_ce_n, s_we_n, s_oe_n, s_dq_oe;
  logic [7:0]  s_rdata, s_dq_out, s_dq_in;
  logic [16:0] s_mem_addr;

  // fast-profile instance
  logic        f_valid = 1'b0;
  logic [16:0] f_addr = '0;
  logic        f_ready, f_rsp, f_ce_n, f_we_n, f_oe_n, f_dq_oe;
  logic [7:0]  f_rdata, f_dq_out, f_dq_in;
  logic [16:0] f_mem_addr;

  pgmem_ctrl #(.FAST(1'b0), .IDLE_CLOSE(IDLE)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(s_valid), .req_ready(s_ready), .req_write(s_write),
    .req_addr(s_addr), .req_wdata(s_wdata),
    .rsp_valid(s_rsp), .rsp_rdata(s_rdata),
    .mem_ce_n(s_ce_n), .mem_we_n(s_we_n), .mem_oe_n(s_oe_n),
    .mem_addr(s_mem_addr), .mem_dq_out(s_dq_out), .mem_dq_oe(s_dq_oe),
    .mem_dq_in(s_dq_in)
  );

  pgmem_ctrl #(.FAST(1'b1), .IDLE_CLOSE(IDLE)) dut_fast (
    .clk(clk), .rst_n(rst_n),
    .req_valid(f_valid), .req_ready(f_ready), .req_write(1'b0),
    .req_addr(f_addr), .req_wdata(8'h00),
    .rsp_valid(f_rsp), .rsp_rdata(f_rdata),
    .mem_ce_n(f_ce_n), .mem_we_n(f_we_n), .mem_oe_n(f_oe_n),
    .mem_addr(f_mem_addr), .mem_dq_out(f_dq_out), .mem_dq_oe(f_dq_oe),
    .mem_dq_in(f_dq_in)
  );

  tb_mem_model m_s (.clk(clk), .ce_n(s_ce_n), .we_n(s_we_n), .oe_n(s_oe_n),
    .addr(s_mem_addr), .dq_out(s_dq_out), .dq_oe(s_dq_oe), .dq_in(s_dq_in));
  tb_mem_model m_f (.clk(clk), .ce_n(f_ce_n), .we_n(f_we_n), .oe_n(f_oe_n),
    .addr(f_mem_addr), .dq_out(f_dq_out), .dq_oe(f_dq_oe), .dq_in(f_dq_in));

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_mem [logic [16:0]];
  logic [7:0] rq [$];

  // monitor counters
  int wr_pulses = 0, ce_rises = 0, viol_r7 = 0, viol_r8 = 0;
  logic prev_we_low = 1'b0, prev_ce_n = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (s_dq_oe && (s_we_n || !s_oe_n)) viol_r8++;
      if (!s_we_n && prev_we_low) viol_r7++;
      if (!s_we_n && !prev_we_low) wr_pulses++;
      if (s_ce_n && !prev_ce_n) ce_rises++;
      if (s_rsp) rq.push_back(s_rdata);
      prev_we_low = !s_we_n;
      prev_ce_n   = s_ce_n;
    end
  end

  function automatic logic [7:0] expv(input logic [16:0] a);
    return exp_mem.exists(a) ? exp_mem[a] : (a[7:0] ^ 8'h5A);
  endfunction

  task automatic chkv(input string rq_tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq_tag, what, act, exp);
    end
  endtask

  task automatic s_issue(input bit w, input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    s_valid = 1'b1; s_write = w; s_addr = a; s_wdata = d;
    while (!s_ready) @(negedge clk);
    @(posedge clk);
    #1 s_valid = 1'b0;
    if (w) exp_mem[a] = d;
  endtask

  task automatic s_read(input logic [16:0] a, input string tag);
    logic [7:0] got;
    s_issue(1'b0, a, 8'h00);
    for (int k = 0; k < 20 && rq.size() == 0; k++) @(posedge clk);
    if (rq.size() == 0) chkv(tag, "no read response", 0, 1);
    else begin
      got = rq.pop_front();
      chkv(tag, "read data", got, expv(a));
    end
  endtask

  // {write, addr, data}
  localparam logic [25:0] VEC [12] = '{
    {1'b1, 17'h00010, 8'h3C}, {1'b1, 17'h00013, 8'hA7},
    {1'b0, 17'h00010, 8'h00}, {1'b0, 17'h00013, 8'h00},
    {1'b1, 17'h1FFF8, 8'h5A}, {1'b1, 17'h1FFFF, 8'hC3},
    {1'b0, 17'h00013, 8'h00}, {1'b0, 17'h1FFFF, 8'h00},
    {1'b1, 17'h0A0A5, 8'h96}, {1'b0, 17'h0A0A5, 8'h00},
    {1'b0, 17'h1FFF8, 8'h00}, {1'b0, 17'h00010, 8'h00}
  };

  bit done = 1'b0;

  initial begin
    int n, cyc, idx, r0;
    bit rdy;
    logic [7:0] got;

    repeat (3) @(negedge clk);
    // R1 reset state
    chkv("R1", "slow pins/handshake",
         {s_ce_n, s_we_n, s_oe_n, s_dq_oe, s_ready, s_rsp}, 6'b111010);
    chkv("R1", "fast pins/handshake",
         {f_ce_n, f_we_n, f_oe_n, f_dq_oe, f_ready, f_rsp}, 6'b111010);
    rst_n = 1'b1;

    // vector table: R2 R9 through read-back
    for (int i = 0; i < 12; i++) begin
      if (VEC[i][25]) s_issue(1'b1, VEC[i][24:8], VEC[i][7:0]);
      else            s_read(VEC[i][24:8], "R2/R9 table");
    end
    repeat (2) @(posedge clk);
    chkv("R7", "write pulses in table", wr_pulses, 5);
    chkv("R3", "row closes in table (R4 row changes)", ce_rises, 6);
    chkv("R7", "we_n low two clocks", viol_r7, 0);
    chkv("R8", "data driver conflicts", viol_r8, 0);

    // R10 idle close, R7 write pins, R11 ready
    for (int k = 0; k < 60 && !s_ce_n; k++) @(negedge clk);
    @(negedge clk);
    s_issue(1'b1, 17'h00040, 8'h71);
    @(negedge clk);
    chkv("R2", "write address", s_mem_addr, 17'h00040);
    chkv("R7", "write pins {we_n,dq_oe,data}", {s_we_n, s_dq_oe, s_dq_out}, {2'b01, 8'h71});
    chkv("R11", "ready in write access", s_ready, 0);
    n = 0;
    @(negedge clk);
    while (!s_ce_n && n < 100) begin
      if (s_we_n) n++;
      @(negedge clk);
    end
    chkv("R10", "open idle clocks before close", n, IDLE);
    chkv("R11", "ready in precharge", s_ready, 0);
    @(negedge clk);
    chkv("R11", "ready when idle", s_ready, 1);

    // R5 burst of eight reads on one open row
    s_read(17'h00040, "R9 open row");
    rq.delete();
    r0 = ce_rises;
    @(negedge clk);
    idx = 0; cyc = 0;
    while (idx < 8 && cyc < 40) begin
      s_valid = 1'b1; s_write = 1'b0; s_addr = 17'h00040 + 17'(idx);
      rdy = s_ready;
      @(posedge clk);
      cyc++;
      if (rdy) idx++;
      @(negedge clk);
    end
    s_valid = 1'b0;
    repeat (4) @(posedge clk);
    chkv("R5", "clocks for 8-read burst", cyc, 8);
    chkv("R3", "ce_n rises during burst", ce_rises - r0, 0);
    chkv("R9", "burst responses", rq.size(), 8);
    for (int i = 0; i < 8; i++) begin
      got = (rq.size() > 0) ? rq.pop_front() : 8'hxx;
      chkv("R9", "burst read data", got, expv(17'h00040 + 17'(i)));
    end

    // R4 slow profile: one precharge clock, no latency clock
    @(negedge clk);
    s_valid = 1'b1; s_write = 1'b0; s_addr = 17'h00200;
    while (!s_ready) @(negedge clk);
    @(posedge clk);
    #1 s_valid = 1'b0;
    @(negedge clk);
    chkv("R4", "slow precharge {ce_n,ready}", {s_ce_n, s_ready}, 2'b10);
    @(negedge clk);
    chkv("R4", "slow access after one precharge {ce_n,oe_n}", {s_ce_n, s_oe_n}, 2'b00);
    @(negedge clk);
    chkv("R9", "slow row-change read", {s_rsp, s_rdata}, {1'b1, 8'h5A});

    // fast profile: R6 latency, R4 two precharge clocks
    @(negedge clk);
    f_valid = 1'b1; f_addr = 17'h00123;
    chkv("R11", "fast ready when idle", f_ready, 1);
    @(posedge clk);
    #1 f_valid = 1'b0;
    @(negedge clk);
    chkv("R6", "latency clock {ce_n,oe_n,ready}", {f_ce_n, f_oe_n, f_ready}, 3'b010);
    @(negedge clk);
    chkv("R8", "fast read access oe_n", f_oe_n, 0);
    chkv("R2", "fast read address", f_mem_addr, 17'h00123);
    @(negedge clk);
    chkv("R9", "fast read response", {f_rsp, f_rdata}, {1'b1, 8'h79});
    @(negedge clk);
    f_valid = 1'b1; f_addr = 17'h01000;
    @(posedge clk);
    #1 f_valid = 1'b0;
    @(negedge clk);
    chkv("R4", "fast precharge clock 1 {ce_n,ready}", {f_ce_n, f_ready}, 2'b10);
    @(negedge clk);
    chkv("R4", "fast precharge clock 2 {ce_n,ready}", {f_ce_n, f_ready}, 2'b10);
    @(negedge clk);
    chkv("R6", "latency after row change {ce_n,oe_n,ready}",
         {f_ce_n, f_oe_n, f_ready}, 3'b010);
    @(negedge clk);
    chkv("R8", "fast access oe_n", f_oe_n, 0);
    @(negedge clk);
    chkv("R9", "fast row-change read", {f_rsp, f_rdata}, {1'b1, 8'h5A});

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule